// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and the calendar date as packed BCD registers: seconds, minutes, hours, day of week, date, month and a two-digit year. A single-cycle enable, pulsed once per second by a prescaler outside the block, advances the count. Every carry resolves within that one tick, so the whole calendar settles in the cycle that follows the pulse. For example, 23:59:59 on the last day of December in year 99 rolls over to 00:00:00 on 01/01/00.

Month ends use the real length of each month. February has 29 days when the year is a multiple of four and 28 days otherwise. The hours field runs in a 24-hour form or in a 12-hour form with an afternoon flag. A bit inside the hours register selects the form.

A host uses a flat register port. A write loads one field, and a write takes priority over a tick that arrives in the same cycle. A combinational read port returns any field by its address.

Top module: `bcd_rtc_counter`

## Requirements
- R1: After reset, hours, minutes, seconds and year read 8'h00. Day of week, date and month read 8'h01. The hours field starts in 24-hour form.
- R2: Seconds and minutes count BCD 8'h00 to 8'h59. Each passes from a 9 in the low digit to the next tens value. On a tick at 8'h59 a field returns to 8'h00 and advances the next field in the same tick.
- R3: In 24-hour form (hours bit 6 = 0) hours count BCD 8'h00 to 8'h23. A tick at 23:59:59 gives 00:00:00 and advances the date.
- R4: In 12-hour form, hours bit 6 is 1, bit 5 is the afternoon flag (1 = PM) and bits 4:0 hold BCD 01..12. Hour 11 goes to 12 and toggles the flag. Hour 12 goes to 01 with the flag unchanged. Only 11 PM going to 12 AM advances the date.
- R5: At the end of the last day of a month the date returns to 8'h01 and the month advances. Months 8'h04, 8'h06, 8'h09 and 8'h11 have 30 days. All other months except February have 31 days.
- R6: February (8'h02) has 29 days when the year (BCD 00..99) is divisible by 4, and 28 days otherwise.
- R7: Month 8'h12 rolls over to 8'h01 and advances the year. Year 8'h99 rolls over to 8'h00.
- R8: Day of week counts 8'h01..8'h07 and wraps to 8'h01. It advances exactly when the date advances.
- R9: When a write and a tick arrive in the same cycle, the written field takes the write data and the tick is discarded for every field.
- R10: With no tick and no write, all fields hold their values.
- R11: Field addresses are seconds 0, minutes 1, hours 2, day of week 3, date 4, month 5 and year 6. A write stores data masked to the field's width: 7F for seconds, minutes and hours, 07 for day of week, 3F for date, 1F for month and FF for year. Address 7 reads 8'h00, and a write to address 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per second |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 3 | Address of the field to write |
| wr_data_i | input | 8 | BCD write data |
| rd_addr_i | input | 3 | Address of the field to read |
| rd_data_o | output | 8 | Field value at rd_addr_i (combinational) |

## Verification
Every field can be read directly, so a wrong count shows on the read port in the cycle after the tick that caused it. A broken carry shows in the neighbouring field during that same tick.

A wrong month length or leap rule stays hidden until a month-end tick. The bench therefore forces the last two days of every month of all one hundred years. It also sweeps an hour of seconds and all 24 hours in both hour forms.

Write priority and masking are checked by writing with a tick in the same cycle and by reading the fields back.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned AW     = 3;
  localparam int unsigned NFIELD = 7;

  typedef enum logic [AW-1:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_DOW  = 3'd3,
    F_DATE = 3'd4,
    F_MON  = 3'd5,
    F_YEAR = 3'd6
  } field_e;

  function automatic logic [DW-1:0] bcd_inc(input logic [DW-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [DW-1:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [DW-1:0] field_mask(input int unsigned idx);
    case (idx)
      int'(F_DOW):  return 8'h07;
      int'(F_DATE): return 8'h3F;
      int'(F_MON):  return 8'h1F;
      int'(F_YEAR): return 8'hFF;
      default:      return 8'h7F;
    endcase
  endfunction

  function automatic logic [DW-1:0] field_rst(input int unsigned idx);
    if (idx == int'(F_DOW) || idx == int'(F_DATE) || idx == int'(F_MON)) return 8'h01;
    return 8'h00;
  endfunction
endpackage

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap
  import rtc_pkg::*;
(
  input  logic          en_i,
  input  logic [DW-1:0] val_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  output logic [DW-1:0] nxt_o,
  output logic          wrap_o
);
  // >= so an out-of-range load still returns to the low bound
  assign wrap_o = en_i && (val_i >= hi_i);

  always_comb begin
    nxt_o = val_i;
    if (en_i) nxt_o = (val_i >= hi_i) ? lo_i : bcd_inc(val_i);
  end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step (
  input  logic       en_i,
  input  logic [6:0] hour_i,
  output logic [6:0] hour_o,
  output logic       day_o
);
  logic       mode12;
  logic       pm;
  logic [4:0] h12_inc;
  logic [5:0] h24_inc;

  assign mode12 = hour_i[6];
  assign pm     = hour_i[5];

  assign h12_inc = (hour_i[3:0] >= 4'd9) ? {hour_i[4] + 1'b1, 4'd0}
                                         : {hour_i[4], hour_i[3:0] + 4'd1};
  assign h24_inc = (hour_i[3:0] >= 4'd9) ? {hour_i[5:4] + 2'd1, 4'd0}
                                         : {hour_i[5:4], hour_i[3:0] + 4'd1};

  always_comb begin
    hour_o = hour_i;
    day_o  = 1'b0;
    if (en_i) begin
      if (mode12) begin
        if (hour_i[4:0] == 5'h11) begin
          hour_o = {1'b1, ~pm, 5'h12};
          day_o  = pm;  // 11 PM -> 12 AM
        end else if (hour_i[4:0] >= 5'h12) begin
          hour_o = {1'b1, pm, 5'h01};
        end else begin
          hour_o = {1'b1, pm, h12_inc};
        end
      end else begin
        if (hour_i[5:0] >= 6'h23) begin
          hour_o = 7'h00;
          day_o  = 1'b1;
        end else begin
          hour_o = {1'b0, h24_inc};
        end
      end
    end
  end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_pkg::*;
(
  input  logic [DW-1:0] month_i,
  input  logic [DW-1:0] year_i,
  output logic [DW-1:0] len_o
);
  logic [6:0] year_bin;
  logic       leap;

  assign year_bin = bcd_to_bin(year_i);
  assign leap     = (year_bin[1:0] == 2'd0);

  always_comb begin
    case (month_i)
      8'h02:                      len_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: len_o = 8'h30;
      default:                    len_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_rtc_counter.sv
module bcd_rtc_counter
  import rtc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] fld_q [NFIELD];
  logic [DW-1:0] fld_n [NFIELD];
  logic [DW-1:0] mlen;
  logic          adv;
  logic          sec_wrap, min_wrap, day_carry, date_wrap, mon_wrap, year_wrap, dow_wrap;
  logic [6:0]    hour_nxt;

  // host write wins: the tick is dropped for the whole chain
  assign adv = tick_i && !wr_en_i;

  rtc_bcd_wrap u_sec (
    .en_i(adv), .val_i(fld_q[F_SEC]), .lo_i(8'h00), .hi_i(8'h59),
    .nxt_o(fld_n[F_SEC]), .wrap_o(sec_wrap)
  );

  rtc_bcd_wrap u_min (
    .en_i(sec_wrap), .val_i(fld_q[F_MIN]), .lo_i(8'h00), .hi_i(8'h59),
    .nxt_o(fld_n[F_MIN]), .wrap_o(min_wrap)
  );

  rtc_hour_step u_hour (
    .en_i(min_wrap), .hour_i(fld_q[F_HOUR][6:0]),
    .hour_o(hour_nxt), .day_o(day_carry)
  );
  assign fld_n[F_HOUR] = {1'b0, hour_nxt};

  rtc_bcd_wrap u_dow (
    .en_i(day_carry), .val_i(fld_q[F_DOW]), .lo_i(8'h01), .hi_i(8'h07),
    .nxt_o(fld_n[F_DOW]), .wrap_o(dow_wrap)
  );

  rtc_month_len u_len (
    .month_i(fld_q[F_MON]), .year_i(fld_q[F_YEAR]), .len_o(mlen)
  );

  rtc_bcd_wrap u_date (
    .en_i(day_carry), .val_i(fld_q[F_DATE]), .lo_i(8'h01), .hi_i(mlen),
    .nxt_o(fld_n[F_DATE]), .wrap_o(date_wrap)
  );

  rtc_bcd_wrap u_mon (
    .en_i(date_wrap), .val_i(fld_q[F_MON]), .lo_i(8'h01), .hi_i(8'h12),
    .nxt_o(fld_n[F_MON]), .wrap_o(mon_wrap)
  );

  rtc_bcd_wrap u_year (
    .en_i(mon_wrap), .val_i(fld_q[F_YEAR]), .lo_i(8'h00), .hi_i(8'h99),
    .nxt_o(fld_n[F_YEAR]), .wrap_o(year_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NFIELD; i++) fld_q[i] <= field_rst(i);
    end else begin
      for (int i = 0; i < NFIELD; i++) begin
        if (wr_en_i && wr_addr_i == AW'(i)) fld_q[i] <= wr_data_i & field_mask(i);
        else if (adv)                       fld_q[i] <= fld_n[i] & field_mask(i);
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NFIELD; i++) begin
      if (rd_addr_i == AW'(i)) rd_data_o = fld_q[i];
    end
  end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [2:0] wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] sec_i,
  input logic [7:0] min_i,
  input logic [7:0] hour_i,
  input logic [7:0] dow_i,
  input logic [7:0] date_i,
  input logic [7:0] mon_i,
  input logic [7:0] year_i,
  input logic       dow_wrap_i,
  input logic       year_wrap_i
);
  p_sec_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !wr_en_i && sec_i == 8'h59 |=> sec_i == 8'h00);

  p_sec_digit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !wr_en_i && sec_i == 8'h09 |=> sec_i == 8'h10);

  p_noon_flip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !wr_en_i && sec_i == 8'h59 && min_i == 8'h59 && hour_i[6] && hour_i[4:0] == 5'h11
    |=> hour_i[4:0] == 5'h12 && hour_i[5] != $past(hour_i[5]));

  p_year_roll_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    year_wrap_i && !wr_en_i |=> year_i == 8'h00);

  p_dow_roll_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dow_wrap_i && !wr_en_i |=> dow_i == 8'h01);

  p_dow_with_date_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(date_i) == $stable(dow_i)));

  p_write_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == 3'd0 |=> sec_i == ($past(wr_data_i) & 8'h7F) && $stable(min_i));

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !wr_en_i |=> $stable(sec_i) && $stable(min_i) && $stable(hour_i) &&
      $stable(dow_i) && $stable(date_i) && $stable(mon_i) && $stable(year_i));
endmodule

bind bcd_rtc_counter rtc_checker u_rtc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .sec_i(fld_q[0]), .min_i(fld_q[1]), .hour_i(fld_q[2]), .dow_i(fld_q[3]),
  .date_i(fld_q[4]), .mon_i(fld_q[5]), .year_i(fld_q[6]),
  .dow_wrap_i(dow_wrap), .year_wrap_i(year_wrap)
);

// File: tb/test_bcd_rtc_counter.sv
module test_bcd_rtc_counter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [2:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bcd_rtc_counter i_bcd_rtc_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] h12_code(input int h24);
    int h;
    h = (h24 % 12 == 0) ? 12 : h24 % 12;
    return 8'h40 | ((h24 >= 12) ? 8'h20 : 8'h00) | bcd(h);
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wr_tick(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; tick_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic tk();
    @(negedge clk_i);
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    rd_addr_i = a;
    #1;
    v = rd_data_o;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] snap [8];
    logic [7:0] rst_exp [8];
    rst_exp = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00};

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 and R11: reset values and the empty address
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk(a == 7 ? "R11" : "R1", $sformatf("reset addr %0d", a), v, rst_exp[a]);
    end

    // R2: one hour of seconds in 24-hour form
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    for (int i = 1; i <= 3600; i++) begin
      tk();
      rd(3'd0, v); chk("R2", "sec", v, bcd(i % 60));
      rd(3'd1, v); chk("R2", "min", v, bcd((i / 60) % 60));
    end
    rd(3'd2, v); chk("R3", "hour after 3600 ticks", v, 8'h01);

    // R3 and R4: every hour in both forms, with the date carry
    for (int mode = 0; mode < 2; mode++) begin
      for (int h = 0; h < 24; h++) begin
        wr(3'd2, mode ? h12_code(h) : bcd(h));
        wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        wr(3'd4, 8'h10); wr(3'd5, 8'h05); wr(3'd3, 8'h03);
        tk();
        rd(3'd2, v);
        chk(mode ? "R4" : "R3", $sformatf("hour step from %0d", h), v,
            mode ? h12_code((h + 1) % 24) : bcd((h + 1) % 24));
        rd(3'd4, v);
        chk(mode ? "R4" : "R3", $sformatf("date carry at %0d", h), v, (h == 23) ? 8'h11 : 8'h10);
        rd(3'd3, v);
        chk("R8", $sformatf("dow step at %0d", h), v, (h == 23) ? 8'h04 : 8'h03);
      end
    end

    // R5, R6 and R7: the last two days of every month over all years
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        string req;
        int len;
        len = mdays(m, y);
        req = (m == 2) ? "R6" : ((m == 12) ? "R7" : "R5");
        wr(3'd6, bcd(y)); wr(3'd5, bcd(m)); wr(3'd4, bcd(len - 1));
        wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        tk();
        rd(3'd4, v); chk(req, $sformatf("date before end %0d/%0d", m, y), v, bcd(len));
        rd(3'd5, v); chk(req, $sformatf("month held %0d/%0d", m, y), v, bcd(m));
        wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        tk();
        rd(3'd4, v); chk(req, $sformatf("date roll %0d/%0d", m, y), v, 8'h01);
        rd(3'd5, v); chk(req, $sformatf("month roll %0d/%0d", m, y), v, bcd(m % 12 + 1));
        rd(3'd6, v); chk("R7", $sformatf("year %0d/%0d", m, y), v, bcd((m == 12) ? (y + 1) % 100 : y));
      end
    end

    // R8: day of week wraps 7 -> 1
    wr(3'd3, 8'h07); wr(3'd4, 8'h05); wr(3'd5, 8'h03);
    wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    tk();
    rd(3'd3, v); chk("R8", "dow wrap", v, 8'h01);
    rd(3'd4, v); chk("R8", "date with dow wrap", v, 8'h06);

    // R9: a write in the same cycle as a tick discards the tick
    wr(3'd2, 8'h05); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    wr_tick(3'd0, 8'h30);
    rd(3'd0, v); chk("R9", "sec written", v, 8'h30);
    rd(3'd1, v); chk("R9", "min untouched", v, 8'h59);
    rd(3'd2, v); chk("R9", "hour untouched", v, 8'h05);
    wr_tick(3'd1, 8'h12);
    rd(3'd0, v); chk("R9", "sec not ticked", v, 8'h30);
    rd(3'd1, v); chk("R9", "min written", v, 8'h12);

    // R10: idle cycles and a write to address 7 change nothing
    for (int a = 0; a < 8; a++) rd(3'(a), snap[a]);
    repeat (5) @(negedge clk_i);
    wr(3'd7, 8'hFF);
    repeat (2) @(negedge clk_i);
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v); chk("R10", $sformatf("hold addr %0d", a), v, snap[a]);
    end
    rd(3'd7, v); chk("R11", "addr 7 after write", v, 8'h00);

    // R11: field masks
    wr(3'd3, 8'hFF); rd(3'd3, v); chk("R11", "dow mask", v, 8'h07);
    wr(3'd4, 8'hFF); rd(3'd4, v); chk("R11", "date mask", v, 8'h3F);
    wr(3'd5, 8'hFF); rd(3'd5, v); chk("R11", "month mask", v, 8'h1F);
    wr(3'd0, 8'hFF); rd(3'd0, v); chk("R11", "sec mask", v, 8'h7F);
    wr(3'd6, 8'hA5); rd(3'd6, v); chk("R11", "year full", v, 8'hA5);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule